// File: doc/BRIEF.md
# Two-Level Page-Table Walker

This block turns a 32-bit virtual address into a physical address. It walks a two-level translation table held in memory. The virtual address is cut into three fields: a 12-bit outer index, a 10-bit inner index and a 10-bit byte offset within a 1 KB page. The walker first reads one 4-byte entry from the outer table, whose location is given by a table base input. That entry names the inner table. The walker then reads the inner entry, which holds the page frame. It checks the valid bit at each level, and checks the writable bit for write accesses. It finishes with either a physical address or a fault code.

A client presents a request while `ready_o` is high. The walker then makes two reads in sequence through a request/acknowledge memory port, and the memory may take any number of cycles to answer each one. Completion is marked by a single-cycle `done_o` strobe. The physical address and the fault code stay on their outputs until the next walk completes. Reporting a fault ends the walk; acting on the fault is left to the client.

Top module: `pt_walker`

## Requirements
- R1: After reset, `ready_o` is 1, and `mem_req_o`, `done_o`, `fault_o`, `paddr_o` and `fault_code_o` are all 0.
- R2: The virtual address is split into outer index = vaddr[31:20], inner index = vaddr[19:10] and offset = vaddr[9:0]. The first read of a walk goes to `pt_base_i` + outer index × 4, using the base value captured when the request was accepted.
- R3: The second read goes to (outer entry bits [31:10] << 10) + inner index × 4. It is issued only after the outer read has been acknowledged with a valid entry.
- R4: Every table entry is 32 bits. Bit 0 is valid, bit 1 is writable, and bits [31:10] hold the frame number. Bits [9:2] are ignored.
- R5: A successful walk gives `paddr_o` = {inner frame number, vaddr[9:0]} with `fault_code_o` = 0 and `fault_o` = 0.
- R6: An outer entry with bit 0 clear ends the walk with `fault_code_o` = 1, for reads and writes alike, and no second read is made.
- R7: An inner entry with bit 0 clear ends the walk with `fault_code_o` = 2.
- R8: A write (`req_write_i` = 1) through a valid inner entry whose bit 1 is clear ends the walk with `fault_code_o` = 3. A read through the same entry translates normally.
- R9: `mem_req_o` stays high, with `mem_addr_o` unchanged, until `mem_ack_i` is sampled high. `mem_rdata_i` is taken in the cycle of the acknowledge.
- R10: `done_o` is high for exactly one cycle per walk. `paddr_o`, `fault_code_o` and `fault_o` change only together with that strobe. On a fault, `paddr_o` is 0 and `fault_o` is 1.
- R11: A request is accepted only while `ready_o` is high. `req_valid_i` raised during a walk has no effect: it neither changes the result nor starts a further walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Translation request |
| req_write_i | input | 1 | Request is for a write access |
| req_vaddr_i | input | 32 | Virtual address to translate |
| pt_base_i | input | 32 | Byte address of the outer table |
| ready_o | output | 1 | Walker is idle and can accept a request |
| mem_req_o | output | 1 | Table read request |
| mem_addr_o | output | 32 | Byte address of the entry being read |
| mem_ack_i | input | 1 | Read acknowledge; data valid in the same cycle |
| mem_rdata_i | input | 32 | Entry read from memory |
| done_o | output | 1 | One-cycle completion strobe |
| paddr_o | output | 32 | Translated physical address (0 on fault) |
| fault_o | output | 1 | Last walk ended in a fault |
| fault_code_o | output | 2 | 0 ok, 1 outer invalid, 2 inner invalid, 3 write protection |

## Verification
The assertions assume that the memory raises `mem_ack_i` only while `mem_req_o` is high, and for one cycle per read, with `mem_rdata_i` valid in that cycle. The bench memory model follows this rule. It acknowledges only a pending request, clears the acknowledge after one cycle, and adds a per-walk latency of zero to two wait cycles, so the hold-until-acknowledge rule is exercised. Any address that was never written reads back as zero, which is an invalid entry, so missing tables produce faults. A stray request is driven mid-walk to test that it is ignored.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int unsigned VA_W      = 32;
  localparam int unsigned PTE_W     = 32;
  localparam int unsigned OFF_W     = 10;
  localparam int unsigned L2_W      = 10;
  localparam int unsigned L1_W      = VA_W - L2_W - OFF_W;
  localparam int unsigned FRAME_W   = PTE_W - OFF_W;
  localparam int unsigned PTE_SHIFT = $clog2(PTE_W / 8);
  localparam int unsigned VLD_BIT   = 0;
  localparam int unsigned WR_BIT    = 1;

  typedef enum logic [1:0] {
    FLT_NONE  = 2'd0,
    FLT_OUTER = 2'd1,
    FLT_INNER = 2'd2,
    FLT_PROT  = 2'd3
  } fault_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OUTER,
    ST_INNER,
    ST_DONE,
    ST_FAULT
  } walk_state_e;
endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
  import ptw_pkg::*;
(
  input  logic [VA_W-1:0]    vaddr_i,
  input  logic [VA_W-1:0]    base_i,
  input  logic [FRAME_W-1:0] tbl_frame_i,
  input  logic               inner_i,
  output logic [VA_W-1:0]    addr_o,
  output logic [OFF_W-1:0]   off_o
);
  logic [L1_W-1:0] p1;
  logic [L2_W-1:0] p2;
  logic [VA_W-1:0] outer_a, inner_a, tbl_base;

  assign {p1, p2, off_o} = vaddr_i;
  assign tbl_base = {tbl_frame_i, {OFF_W{1'b0}}};
  // inner table spans several frames, so add rather than OR
  assign outer_a  = base_i   + (VA_W'(p1) << PTE_SHIFT);
  assign inner_a  = tbl_base + (VA_W'(p2) << PTE_SHIFT);
  assign addr_o   = inner_i ? inner_a : outer_a;
endmodule

// File: rtl/ptw_pte_decode.sv
module ptw_pte_decode
  import ptw_pkg::*;
(
  input  logic [PTE_W-1:0]   pte_i,
  input  logic               inner_i,
  input  logic               write_i,
  output logic [FRAME_W-1:0] frame_o,
  output fault_e             fault_o
);
  logic vld, wr;
  logic rsvd_unused;

  assign vld         = pte_i[VLD_BIT];
  assign wr          = pte_i[WR_BIT];
  assign frame_o     = pte_i[PTE_W-1:OFF_W];
  assign rsvd_unused = ^pte_i[OFF_W-1:WR_BIT+1];

  always_comb begin
    if (!vld)                         fault_o = inner_i ? FLT_INNER : FLT_OUTER;
    else if (inner_i && write_i && !wr) fault_o = FLT_PROT;
    else                              fault_o = FLT_NONE;
  end

  always_comb begin
    if (!inner_i) a_r6_outer_no_prot: assert (fault_o != FLT_PROT && fault_o != FLT_INNER);
  end
endmodule

// File: rtl/ptw_result_reg.sv
module ptw_result_reg
  import ptw_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [VA_W-1:0] paddr_i,
  input  fault_e          fault_i,
  output logic [VA_W-1:0] paddr_o,
  output fault_e          fault_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      paddr_o <= '0;
      fault_o <= FLT_NONE;
    end else if (load_i) begin
      paddr_o <= (fault_i == FLT_NONE) ? paddr_i : '0;
      fault_o <= fault_i;
    end
  end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic             req_write_i,
  input  logic [VA_W-1:0]  req_vaddr_i,
  input  logic [VA_W-1:0]  pt_base_i,
  output logic             ready_o,
  output logic             mem_req_o,
  output logic [VA_W-1:0]  mem_addr_o,
  input  logic             mem_ack_i,
  input  logic [PTE_W-1:0] mem_rdata_i,
  output logic             done_o,
  output logic [VA_W-1:0]  paddr_o,
  output logic             fault_o,
  output logic [1:0]       fault_code_o
);
  walk_state_e        state_q, state_d;
  logic [VA_W-1:0]    vaddr_q, base_q;
  logic               wr_q;
  logic [FRAME_W-1:0] tbl_frame_q;

  logic               in_inner;
  logic [OFF_W-1:0]   off;
  logic [FRAME_W-1:0] dec_frame;
  fault_e             dec_fault, res_fault;
  logic               res_load;

  assign in_inner = (state_q == ST_INNER);

  ptw_addr_gen u_addr (
    .vaddr_i     (vaddr_q),
    .base_i      (base_q),
    .tbl_frame_i (tbl_frame_q),
    .inner_i     (in_inner),
    .addr_o      (mem_addr_o),
    .off_o       (off)
  );

  ptw_pte_decode u_dec (
    .pte_i   (mem_rdata_i),
    .inner_i (in_inner),
    .write_i (wr_q),
    .frame_o (dec_frame),
    .fault_o (dec_fault)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (req_valid_i) state_d = ST_OUTER;
      ST_OUTER: if (mem_ack_i)   state_d = (dec_fault != FLT_NONE) ? ST_FAULT : ST_INNER;
      ST_INNER: if (mem_ack_i)   state_d = (dec_fault != FLT_NONE) ? ST_FAULT : ST_DONE;
      default:                   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      vaddr_q     <= '0;
      base_q      <= '0;
      wr_q        <= 1'b0;
      tbl_frame_q <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && req_valid_i) begin
        vaddr_q <= req_vaddr_i;
        base_q  <= pt_base_i;
        wr_q    <= req_write_i;
      end
      if (state_q == ST_OUTER && mem_ack_i) tbl_frame_q <= dec_frame;
    end
  end

  assign res_load = (state_d == ST_DONE || state_d == ST_FAULT) &&
                    (state_q == ST_OUTER || state_q == ST_INNER);

  ptw_result_reg u_res (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (res_load),
    .paddr_i ({dec_frame, off}),
    .fault_i (dec_fault),
    .paddr_o (paddr_o),
    .fault_o (res_fault)
  );

  assign ready_o      = (state_q == ST_IDLE);
  assign mem_req_o    = (state_q == ST_OUTER) || in_inner;
  assign done_o       = (state_q == ST_DONE) || (state_q == ST_FAULT);
  assign fault_code_o = res_fault;
  assign fault_o      = (res_fault != FLT_NONE);

  a_r9_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o));
  a_r10_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r10_result_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(paddr_o) && $stable(fault_code_o));
  a_r10_fault_zero_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && fault_o |-> paddr_o == '0);
  a_r11_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> !mem_req_o && !done_o);
  a_r8_prot_needs_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && fault_code_o == FLT_PROT |-> wr_q);
  a_r3_inner_after_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_inner && !$past(in_inner) |-> $past(mem_ack_i));
endmodule

// File: tb/pt_walker_bench.sv
module pt_walker_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_vaddr = '0, pt_base = '0;
  logic        ready, mem_req, mem_ack = 1'b0, done, fault;
  logic [31:0] mem_addr, mem_rdata = '0, paddr;
  logic [1:0]  fault_code;

  always #4 clk = ~clk;

  pt_walker u_pt_walker (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_write_i(req_write),
    .req_vaddr_i(req_vaddr), .pt_base_i(pt_base), .ready_o(ready), .mem_req_o(mem_req),
    .mem_addr_o(mem_addr), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata), .done_o(done),
    .paddr_o(paddr), .fault_o(fault), .fault_code_o(fault_code)
  );

  localparam logic [31:0] BASE = 32'h0001_0000;

  // memory model: unwritten locations read as 0 (invalid entry)
  logic [31:0] mem [logic [31:0]];
  logic [31:0] rd_log [64];
  int unsigned rd_n = 0, wait_cnt = 0, lat = 0;

  always @(posedge clk) begin
    mem_ack <= 1'b0;
    if (mem_req && !mem_ack) begin
      if (wait_cnt >= lat) begin
        mem_ack   <= 1'b1;
        mem_rdata <= mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
        rd_log[rd_n % 64] <= mem_addr;
        rd_n      <= rd_n + 1;
        wait_cnt  <= 0;
      end else wait_cnt <= wait_cnt + 1;
    end
  end

  int n_chk = 0, n_err = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // {vaddr, write, expected paddr, expected fault code}
  localparam int NV = 10;
  localparam logic [66:0] VEC [NV] = '{
    {32'h0010_0123, 1'b0, 32'h048D_1523, 2'd0},  // R5 read
    {32'h0010_03FF, 1'b1, 32'h048D_17FF, 2'd0},  // R5 write to writable page
    {32'h0010_1400, 1'b0, 32'hFFFF_FC00, 2'd0},  // R8 read of read-only page
    {32'h0010_142A, 1'b1, 32'h0000_0000, 2'd3},  // R8 write to read-only page
    {32'h0010_1C00, 1'b0, 32'h0000_0000, 2'd2},  // R7 inner invalid
    {32'h0020_0000, 1'b0, 32'h0000_0000, 2'd1},  // R6 outer invalid
    {32'h0020_0000, 1'b1, 32'h0000_0000, 2'd1},  // R6 outer invalid on write
    {32'hFFFF_FFFF, 1'b1, 32'h0000_07FF, 2'd0},  // R2 last outer/inner index
    {32'h0000_0010, 1'b0, 32'h0000_0000, 2'd1},  // R6 absent outer entry
    {32'hFFF0_0400, 1'b0, 32'h0000_0000, 2'd2}   // R7 absent inner entry
  };

  task automatic wait_done(output bit ok);
    int t = 0;
    while (!done && t < 200) begin @(negedge clk); t++; end
    ok = done;
    if (!ok) chk(1'b0, "R10 walk timeout", 32'(t), 32'd200);
  endtask

  task automatic start(input logic [31:0] va, input logic wr);
    req_vaddr = va; req_write = wr; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; req_vaddr = 32'h0020_0000; req_write = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    chk(1'b0, "watchdog", 32'h0, 32'h1);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    bit ok;
    // outer entries: frame in [31:10], valid bit 0
    mem[BASE + 32'h4]    = 32'h0004_0001;  // p1=1  -> inner table 0x40000
    mem[BASE + 32'h3FFC] = 32'h0008_0001;  // p1=FFF -> inner table 0x80000
    mem[BASE + 32'h8]    = 32'h0005_0002;  // p1=2  invalid (R4 bit 1 ignored)
    mem[32'h0004_0000]   = 32'h048D_17FF;  // R4 frame 12345, rw, reserved bits set
    mem[32'h0004_0014]   = 32'hFFFF_FC01;  // frame 3FFFFF, read-only
    mem[32'h0004_001C]   = 32'h0000_1002;  // invalid
    mem[32'h0008_0FFC]   = 32'h0000_0403;  // frame 1, rw
    pt_base = BASE;

    repeat (3) @(negedge clk);
    // R1 reset state
    chk(ready === 1'b1,   "R1 ready",      {31'b0, ready}, 32'h1);
    chk(mem_req === 1'b0, "R1 mem_req",    {31'b0, mem_req}, 32'h0);
    chk(done === 1'b0,    "R1 done",       {31'b0, done}, 32'h0);
    chk(fault === 1'b0,   "R1 fault",      {31'b0, fault}, 32'h0);
    chk(paddr === 32'h0,  "R1 paddr",      paddr, 32'h0);
    chk(fault_code === 2'd0, "R1 code",    {30'b0, fault_code}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [31:0] va, ep, oa, ia;
      logic        wr;
      logic [1:0]  ec;
      int unsigned n0;
      {va, wr, ep, ec} = VEC[i];
      lat = i % 3;  // R9 exercised with 0..2 wait cycles
      n0 = rd_n;
      start(va, wr);
      wait_done(ok);
      if (!ok) continue;
      chk(paddr === ep, "R5/R10 paddr", paddr, ep);
      chk(fault_code === ec, "R6/R7/R8 fault_code", {30'b0, fault_code}, {30'b0, ec});
      chk(fault === (ec != 0), "R10 fault flag", {31'b0, fault}, {31'b0, ec != 0});
      oa = BASE + {18'b0, va[31:20], 2'b0};
      chk(rd_log[n0 % 64] === oa, "R2 outer address", rd_log[n0 % 64], oa);
      if (ec == 2'd1) begin
        chk(rd_n - n0 == 1, "R6 single read", 32'(rd_n - n0), 32'd1);
      end else begin
        ia = {mem[oa][31:10], 10'b0} + {20'b0, va[19:10], 2'b0};
        chk(rd_n - n0 == 2, "R3 two reads", 32'(rd_n - n0), 32'd2);
        chk(rd_log[(n0 + 1) % 64] === ia, "R3 inner address", rd_log[(n0 + 1) % 64], ia);
      end
      @(negedge clk);
      chk(done === 1'b0, "R10 done one cycle", {31'b0, done}, 32'h0);
      chk(paddr === ep, "R10 paddr held", paddr, ep);
      chk(ready === 1'b1, "R11 ready after walk", {31'b0, ready}, 32'h1);
    end

    // R11: request during walk is ignored
    begin
      int unsigned n0;
      lat = 2;
      n0 = rd_n;
      start(32'h0010_0123, 1'b0);
      chk(ready === 1'b0, "R11 busy", {31'b0, ready}, 32'h0);
      req_vaddr = 32'h0020_0000; req_write = 1'b1; req_valid = 1'b1;
      @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      wait_done(ok);
      if (ok) begin
        chk(paddr === 32'h048D_1523, "R11 result of first request", paddr, 32'h048D_1523);
        chk(fault_code === 2'd0, "R11 no fault", {30'b0, fault_code}, 32'h0);
      end
      repeat (4) @(negedge clk);
      chk(mem_req === 1'b0, "R11 no second walk", {31'b0, mem_req}, 32'h0);
      chk(rd_n - n0 == 2, "R11 read count", 32'(rd_n - n0), 32'd2);
      chk(paddr === 32'h048D_1523, "R10 held while idle", paddr, 32'h048D_1523);
    end

    // R2: base captured at accept, later change has no effect
    begin
      int unsigned n0;
      lat = 1;
      n0 = rd_n;
      start(32'h0010_1400, 1'b0);
      pt_base = 32'h00F0_0000;
      wait_done(ok);
      if (ok) begin
        chk(rd_log[n0 % 64] === BASE + 32'h4, "R2 base captured", rd_log[n0 % 64], BASE + 32'h4);
        chk(paddr === 32'hFFFF_FC00, "R2 translation with captured base", paddr, 32'hFFFF_FC00);
      end
      pt_base = BASE;
      @(negedge clk);
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule